// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address of up to 52 bits. It walks a four-level tree of page tables. Each table holds 512 entries of 64 bits. A request supplies the virtual address and a 64-bit root register. The walker then issues one aligned 64-bit read per level on a valid/ready memory port and waits for each response before it goes on. The result is a physical address and a page size, or a fault code.

The 48 low virtual bits are split into four 9-bit table indices and a 12-bit byte offset. The top index selects the root entry. Before any read, the walker checks that the address is canonical. A large-page flag in the second-level or third-level entry ends the walk early with a 1 GB or 2 MB page. Only one translation is in flight at a time. Each translation finishes with a one-cycle done pulse.

Top module: `pw_walker`

## Requirements
- R1: If any of virtual bits 63:48 differs from bit 47, the walker makes no memory read. It raises done with fault_o=1 and fault_code_o=7 in the cycle after the request is accepted.
- R2: The first read address is {root bits 51:12, VA bits 47:39, 3'b000}. The reads for levels 2, 3 and 4 use index VA bits 38:30, 29:21 and 20:12 in the same form. Every read address is 8-byte aligned.
- R3: The table base for each level after the first comes from bits 51:12 of the entry fetched at the level before. Entry bits 63:52 have no effect on any address.
- R4: A present level-2 entry with bit 7 set ends the walk after two reads. The result is pa_o = {entry bits 51:30, VA bits 29:0} and page_size_o=2 (1 GB).
- R5: A present level-3 entry with bit 7 set ends the walk after three reads. The result is pa_o = {entry bits 51:21, VA bits 20:0} and page_size_o=1 (2 MB).
- R6: Otherwise the walk takes four reads. The result is pa_o = {level-4 entry bits 51:12, VA bits 11:0} and page_size_o=0 (4 KB).
- R7: An entry with bit 0 (present) clear ends the walk at once. The walker raises fault_o=1 with fault_code_o equal to the failing level, 1 to 4. A successful walk gives fault_code_o=0, fault_o=0 and pa_o=0 when it faults.
- R8: Bit 7 of a level-1 or level-4 entry has no effect on the walk or on the result.
- R9: req_ready_o is high only while idle. A memory request holds its address stable until it is accepted. No new request is issued while a response is outstanding.
- R10: After reset the walker is idle, with req_ready_o=1, done_o=0 and mem_req_valid_o=0. done_o is a single-cycle pulse for each translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 64 | Virtual address |
| root_base_i | input | 64 | Root table register (bits 51:12 used) |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts read |
| mem_addr_o | output | 52 | Entry physical byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Fetched table entry |
| done_o | output | 1 | Translation finished (one cycle) |
| pa_o | output | 52 | Physical address |
| page_size_o | output | 2 | 0=4 KB, 1=2 MB, 2=1 GB |
| fault_o | output | 1 | Translation faulted |
| fault_code_o | output | 3 | 0 ok, 1..4 not-present level, 7 non-canonical |

## Verification
The bench builds the walker with its default parameters: a 64-bit virtual address, a 52-bit physical address, 9-bit indices and a 12-bit offset. This brings all three page sizes within reach, along with non-canonical addresses on either side of bit 47 and every fault level. Random entries with random present and size bits produce each termination point. Random stalls on the memory side exercise request hold and response latency. Entries with bits above 51 and bit 7 set at the top and bottom levels show that those bits are ignored.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2,
    S_DONE = 2'd3
  } walk_state_e;

  localparam logic [2:0] CODE_OK       = 3'd0;
  localparam logic [2:0] CODE_NONCANON = 3'd7;
  localparam int unsigned PRESENT_BIT  = 0;
  localparam int unsigned SIZE_BIT     = 7;
endpackage

// File: rtl/pw_canon_chk.sv
module pw_canon_chk #(
  parameter int unsigned VA_W    = 64,
  parameter int unsigned VA_USED = 48
) (
  input  logic [VA_W-1:0] va_i,
  output logic            canon_o
);
  localparam int unsigned TOP_W = VA_W - VA_USED + 1;
  logic [TOP_W-1:0] top;
  assign top     = va_i[VA_W-1:VA_USED-1];
  assign canon_o = (&top) | ~(|top);
  logic unused_low;
  assign unused_low = ^va_i[VA_USED-2:0];
endmodule

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 52,
  localparam int unsigned PFN_W = PA_W - OFF_W,
  localparam int unsigned LVL_W = $clog2(LEVELS),
  localparam int unsigned IDXS_W = LEVELS * IDX_W
) (
  input  logic [PFN_W-1:0]  base_i,
  input  logic [IDXS_W-1:0] vidx_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [PA_W-1:0]   addr_o
);
  localparam int unsigned ENT_B = OFF_W - IDX_W;
  logic [IDX_W-1:0] idx [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx[g] = vidx_i[(LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign addr_o = {base_i, idx[lvl_i], {ENT_B{1'b0}}};
endmodule

// File: rtl/pw_leaf_pa.sv
module pw_leaf_pa #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 52,
  localparam int unsigned VA_USED = OFF_W + LEVELS * IDX_W,
  localparam int unsigned LVL_W   = $clog2(LEVELS)
) (
  input  logic [PA_W-1:0]    ent_i,
  input  logic [VA_USED-1:0] va_i,
  input  logic [LVL_W-1:0]   lvl_i,
  output logic [PA_W-1:0]    pa_o
);
  logic [PA_W-1:0] cand [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_leaf
    localparam int unsigned SPAN = OFF_W + (LEVELS - 1 - g) * IDX_W;
    assign cand[g] = {ent_i[PA_W-1:SPAN], va_i[SPAN-1:0]};
  end

  assign pa_o = cand[lvl_i];

  logic unused_bits;
  assign unused_bits = ^{ent_i[OFF_W-1:0], va_i[VA_USED-1:VA_USED-IDX_W]};
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
#(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned PA_W   = 52,
  parameter int unsigned ENT_W  = 64,
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFF_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic [63:0]      root_base_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [ENT_W-1:0] mem_rsp_data_i,
  output logic             done_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [1:0]       page_size_o,
  output logic             fault_o,
  output logic [2:0]       fault_code_o
);
  localparam int unsigned VA_USED = OFF_W + LEVELS * IDX_W;
  localparam int unsigned PFN_W   = PA_W - OFF_W;
  localparam int unsigned LVL_W   = $clog2(LEVELS);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_state_e          state_q;
  logic [LVL_W-1:0]     lvl_q;
  logic [PFN_W-1:0]     base_q;
  logic [VA_USED-1:0]   va_q;
  logic [PA_W-1:0]      pa_q;
  logic [1:0]           size_q;
  logic [2:0]           code_q;
  logic                 canon;
  logic [PA_W-1:0]      leaf_pa;
  logic                 present, big, leaf;

  pw_canon_chk #(.VA_W(VA_W), .VA_USED(VA_USED)) u_canon (
    .va_i(req_va_i), .canon_o(canon)
  );

  pw_entry_addr #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_addr (
    .base_i(base_q), .vidx_i(va_q[VA_USED-1:OFF_W]), .lvl_i(lvl_q), .addr_o(mem_addr_o)
  );

  pw_leaf_pa #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_leaf (
    .ent_i(mem_rsp_data_i[PA_W-1:0]), .va_i(va_q), .lvl_i(lvl_q), .pa_o(leaf_pa)
  );

  assign present = mem_rsp_data_i[PRESENT_BIT];
  // page-size flag honoured only between the top and bottom levels
  assign big  = mem_rsp_data_i[SIZE_BIT] && (lvl_q != '0);
  assign leaf = big || (lvl_q == LAST_LVL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      lvl_q   <= '0;
      base_q  <= '0;
      va_q    <= '0;
      pa_q    <= '0;
      size_q  <= '0;
      code_q  <= CODE_OK;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q   <= req_va_i[VA_USED-1:0];
          base_q <= root_base_i[PA_W-1:OFF_W];
          lvl_q  <= '0;
          pa_q   <= '0;
          size_q <= '0;
          if (canon) begin
            code_q  <= CODE_OK;
            state_q <= S_REQ;
          end else begin
            code_q  <= CODE_NONCANON;
            state_q <= S_DONE;
          end
        end
        S_REQ: if (mem_req_ready_i) state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid_i) begin
          if (!present) begin
            code_q  <= 3'(lvl_q) + 3'd1;
            state_q <= S_DONE;
          end else if (leaf) begin
            pa_q    <= leaf_pa;
            size_q  <= 2'(LAST_LVL - lvl_q);
            state_q <= S_DONE;
          end else begin
            base_q  <= mem_rsp_data_i[PA_W-1:OFF_W];
            lvl_q   <= lvl_q + 1'b1;
            state_q <= S_REQ;
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == S_IDLE);
  assign mem_req_valid_o = (state_q == S_REQ);
  assign done_o          = (state_q == S_DONE);
  assign pa_o            = pa_q;
  assign page_size_o     = size_q;
  assign fault_o         = done_o && (code_q != CODE_OK);
  assign fault_code_o    = done_o ? code_q : CODE_OK;

  logic unused_in;
  assign unused_in = ^{mem_rsp_data_i[ENT_W-1:PA_W], root_base_i[63:PA_W],
                       root_base_i[OFF_W-1:0], req_va_i[VA_W-1:VA_USED]};

  a_r1_noncanon_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_code_o == CODE_NONCANON) |-> $past(req_valid_i && req_ready_o));
  a_r2_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_addr_o[2:0] == 3'b000));
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));
  a_r9_no_req_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o);
  a_r9_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> ((fault_code_o >= 3'd1 && fault_code_o <= 3'd4)
                             || fault_code_o == CODE_NONCANON));
  a_r7_fault_pa_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (pa_o == '0));
endmodule

// File: tb/pw_walker_tb.sv
module pw_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [63:0] req_va_i = '0;
  logic [63:0] root_base_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [51:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        done_o;
  logic [51:0] pa_o;
  logic [1:0]  page_size_o;
  logic        fault_o;
  logic [2:0]  fault_code_o;

  int checks = 0;
  int fails  = 0;
  bit hung   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pw_walker u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_va_i, .root_base_i,
    .mem_req_valid_o, .mem_req_ready_i, .mem_addr_o, .mem_rsp_valid_i,
    .mem_rsp_data_i, .done_o, .pa_o, .page_size_o, .fault_o, .fault_code_o
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] canon_va();
    logic [47:0] v = {$urandom(), $urandom()};
    return {{16{v[47]}}, v};
  endfunction

  // expected walk: read addresses, read count, result
  task automatic run_walk(input logic [63:0] va, input logic [63:0] root,
                          input logic [63:0] ent [4], input string tag);
    logic [51:0] exp_addr [4];
    logic [39:0] base = root[51:12];
    logic [51:0] exp_pa = '0;
    logic [1:0]  exp_sz = 0;
    logic [2:0]  exp_code = 0;
    int          exp_reads = 0;
    int          n = 0;
    int          guard = 0;
    bit          canon = (va[63:47] == '0) || (va[63:47] == '1);
    if (!canon) exp_code = 3'd7;
    else begin
      for (int l = 0; l < 4; l++) begin
        logic [63:0] e = ent[l];
        exp_addr[l] = {base, va[47 - 9*l -: 9], 3'b000};
        exp_reads = l + 1;
        if (!e[0]) begin exp_code = 3'(l + 1); break; end
        if (l == 1 && e[7]) begin exp_pa = {e[51:30], va[29:0]}; exp_sz = 2; break; end
        if (l == 2 && e[7]) begin exp_pa = {e[51:21], va[20:0]}; exp_sz = 1; break; end
        if (l == 3) begin exp_pa = {e[51:12], va[11:0]}; exp_sz = 0; break; end
        base = e[51:12];
      end
    end
    @(negedge clk_i);
    check(req_ready_o == 1'b1, "R9 idle ready", 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1; req_va_i = va; root_base_i = root;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(req_ready_o == 1'b0, "R9 busy", 64'(req_ready_o), 64'd0);
    forever begin
      mem_rsp_valid_i = 1'b0;
      if (done_o) break;
      if (++guard > 200) begin hung = 1; break; end
      if (mem_req_valid_o) begin
        repeat ($urandom() % 3) @(negedge clk_i);
        if (n < 4)
          check(mem_addr_o == exp_addr[n], $sformatf("R2/R3 %s read %0d", tag, n),
                64'(mem_addr_o), 64'(exp_addr[n]));
        mem_req_ready_i = 1'b1;
        @(negedge clk_i);
        mem_req_ready_i = 1'b0;
        check(mem_req_valid_o == 1'b0, "R9 one outstanding", 64'(mem_req_valid_o), 64'd0);
        repeat ($urandom() % 3) @(negedge clk_i);
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = (n < 4) ? ent[n] : 64'd0;
        n++;
      end
      @(negedge clk_i);
    end
    if (hung) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      return;
    end
    check(n == exp_reads, $sformatf("%s read count", tag), 64'(n), 64'(exp_reads));
    check(fault_code_o == exp_code, $sformatf("%s code", tag), 64'(fault_code_o), 64'(exp_code));
    check(fault_o == (exp_code != 0), $sformatf("R7 %s fault", tag), 64'(fault_o),
          64'(exp_code != 0));
    check(pa_o == exp_pa, $sformatf("%s pa", tag), 64'(pa_o), 64'(exp_pa));
    if (exp_code == 0)
      check(page_size_o == exp_sz, $sformatf("%s size", tag), 64'(page_size_o), 64'(exp_sz));
    @(negedge clk_i);
    check(done_o == 1'b0, "R10 done pulse", 64'(done_o), 64'd0);
  endtask

  function automatic logic [63:0] rnd_ent(input bit p, input bit ps);
    logic [63:0] e = {$urandom(), $urandom()};
    e[0] = p; e[7] = ps;
    return e;
  endfunction

  initial begin
    logic [63:0] ent [4];
    logic [63:0] va;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check(req_ready_o == 1'b1 && done_o == 1'b0 && mem_req_valid_o == 1'b0,
          "R10 reset state", {61'd0, req_ready_o, done_o, mem_req_valid_o}, 64'h4);
    rst_ni = 1'b1;

    for (int l = 0; l < 4; l++) ent[l] = rnd_ent(1, 0);
    va = canon_va(); va[47] = 1'b0; va[50] = 1'b1;
    run_walk(va, {$urandom(), $urandom()}, ent, "R1 noncanon high");
    va = canon_va(); va[47] = 1'b1; va[63] = 1'b0;
    run_walk(va, {$urandom(), $urandom()}, ent, "R1 noncanon neg");

    va = canon_va();
    for (int l = 0; l < 4; l++) ent[l] = rnd_ent(1, 0);
    run_walk(va, {$urandom(), $urandom()}, ent, "R6 4k");
    ent[2][7] = 1'b1;
    run_walk(va, {$urandom(), $urandom()}, ent, "R5 2m");
    ent[1][7] = 1'b1;
    run_walk(va, {$urandom(), $urandom()}, ent, "R4 1g");

    for (int f = 0; f < 4; f++) begin
      for (int l = 0; l < 4; l++) ent[l] = rnd_ent(1, 0);
      ent[f][0] = 1'b0;
      run_walk(canon_va(), {$urandom(), $urandom()}, ent, $sformatf("R7 level%0d", f + 1));
    end

    for (int l = 0; l < 4; l++) ent[l] = rnd_ent(1, 0);
    ent[0][7] = 1'b1; ent[3][7] = 1'b1;
    run_walk(canon_va(), {$urandom(), $urandom()}, ent, "R8 ignored size bits");

    for (int l = 0; l < 4; l++) begin ent[l] = rnd_ent(1, 0); ent[l][63:52] = 12'hfff; end
    run_walk(canon_va(), 64'hfff0_0000_0000_0fff | {12'd0, 40'h12345_6789, 12'd0}, ent,
             "R3 high bits");

    for (int i = 0; i < 80 && !hung; i++) begin
      for (int l = 0; l < 4; l++) ent[l] = rnd_ent(($urandom() % 10) != 0, $urandom() % 2);
      va = canon_va();
      if ($urandom() % 8 == 0) va[48 + $urandom() % 16] ^= 1'b1;
      run_walk(va, {$urandom(), $urandom()}, ent, "R2 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule